// File: doc/BRIEF.md
# Peripheral DMA Channel Sequencer

This block is one DMA channel that moves items between a single peripheral and memory over a 16-bit access bus. Software programs a mode (direction, item size and one- or two-dimensional walk), a start address, an inner count with its stride, and an outer count with its stride, and then raises the enable. On the rising edge of the enable, the channel checks the settings. If they are legal, it loads its pointer and counters and starts serving requests.

While the channel is enabled, each pulse on the peripheral interrupt line is taken as a DMA request. Each accepted request moves exactly one item. A 32-bit item goes out as two bus beats, the low half first. After every item, the pointer advances by the inner stride. In two-dimensional mode, the outer stride is applied instead at the end of each row. When the channel is disabled, the interrupt line is passed straight through to the interrupt controller.

When the last item completes, the channel pulses `done` and then absorbs any further requests until software drops the enable. Illegal settings raise `cfg_err` instead, and the channel makes no bus access.

Top module: `pdma_channel`

## Requirements
- R1: While `cfg_enable` is 0, `irq_out` equals `periph_irq` in the same cycle. While `cfg_enable` is 1, `irq_out` is 0.
- R2: `mem_write` is 1 for transfers from peripheral to memory (`cfg_to_mem`=1) and 0 for transfers from memory to peripheral. The direction is latched on the rising edge of the enable.
- R3: In 1D mode the first item is at `cfg_start_addr`. Each following item is at the previous item address plus the sign-extended `cfg_x_mod`. The transfer ends after `cfg_x_count` items.
- R4: In 2D mode, after every `cfg_x_count` items the pointer adds the sign-extended `cfg_y_mod` instead of `cfg_x_mod`, and the row count reloads. The transfer ends after `cfg_y_count` rows.
- R5: Size code 2 (32-bit) issues two beats, at the pointer and at the pointer plus 2. Writes drive `periph_wdata[15:0]` on the first beat and `periph_wdata[31:16]` on the second. Reads return `{second beat, first beat}` on `periph_rdata`, with a one-cycle `periph_rvalid`.
- R6: Size code 0 (8-bit, `mem_byte`=1) and size code 1 (16-bit) use one beat per item. An 8-bit read returns the low byte zero-extended. Exactly one item is moved per accepted request, and a request arriving while an item is in flight is dropped. A beat holds its address until `mem_ready`.
- R7: If a stride used by the mode is not a multiple of the item size (1, 2 or 4 bytes), `cfg_err` rises one cycle after the enable edge. The channel then makes no bus access and stays not busy until disabled. `cfg_y_mod` is not checked in 1D mode.
- R8: With `narrow_only`=1, size code 2 raises `cfg_err`. Size code 3 always raises `cfg_err`.
- R9: `done` is high for exactly one cycle, in the cycle after the final beat's handshake. `busy` drops at the same time. Requests made after that produce no bus access and no `irq_out` while the channel stays enabled.
- R10: A count value of 0 means 2^CW items (or rows).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Channel enable; rising edge starts a transfer |
| cfg_to_mem | input | 1 | 1 = write memory, 0 = read memory |
| cfg_size | input | 2 | Item size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = illegal |
| cfg_two_d | input | 1 | 1 = two-dimensional walk |
| cfg_start_addr | input | AW | Byte address of the first item |
| cfg_x_count | input | CW | Items per row (0 = 2^CW) |
| cfg_x_mod | input | MW | Signed inner stride in bytes |
| cfg_y_count | input | CW | Rows (0 = 2^CW), 2D only |
| cfg_y_mod | input | MW | Signed row-end stride in bytes, 2D only |
| narrow_only | input | 1 | Channel limited to items of 16 bits or less |
| periph_irq | input | 1 | Peripheral interrupt / request pulse |
| periph_wdata | input | 2*DW | Item from the peripheral, captured with the request |
| irq_out | output | 1 | Interrupt forwarded to the interrupt controller |
| periph_rdata | output | 2*DW | Item read from memory |
| periph_rvalid | output | 1 | One-cycle strobe for `periph_rdata` |
| mem_valid | output | 1 | Bus beat request |
| mem_ready | input | 1 | Bus beat grant |
| mem_addr | output | AW | Beat byte address |
| mem_write | output | 1 | Beat is a write |
| mem_byte | output | 1 | Beat carries one byte |
| mem_wdata | output | DW | Beat write data |
| mem_rdata | input | DW | Beat read data, valid with `mem_ready` |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Configuration rejected |

## Verification
The assertions assume the configuration fields stay unchanged while the enable is high. They also assume that `mem_ready` answers only an active beat, so a grant never arrives without a request. The bench changes configuration only while the channel is disabled. It drives `mem_ready` either continuously high or on alternate cycles. The interrupt line follows a fixed repeating pattern, so some requests are made while an item is still in flight and are dropped.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    typedef enum logic [1:0] {
        ISZ_8    = 2'd0,
        ISZ_16   = 2'd1,
        ISZ_32   = 2'd2,
        ISZ_RSVD = 2'd3
    } item_size_e;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_RUN,
        CH_FIN,
        CH_ERR
    } chan_state_e;

    typedef struct packed {
        logic       to_mem;
        item_size_e size;
    } xfer_mode_t;

    // Stride alignment test on the two low bits of a byte stride.
    function automatic logic stride_fits(input item_size_e sz, input logic [1:0] low);
        case (sz)
            ISZ_8:   return 1'b1;
            ISZ_16:  return ~low[0];
            ISZ_32:  return (low == 2'b00);
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pdma_cfg_check.sv
module pdma_cfg_check
    import pdma_pkg::*;
(
    input  item_size_e size,
    input  logic       two_d,
    input  logic [1:0] x_low,
    input  logic [1:0] y_low,
    input  logic       narrow_only,
    output logic       legal
);
    logic x_ok;
    logic y_ok;
    logic size_ok;

    always_comb begin
        x_ok    = stride_fits(size, x_low);
        y_ok    = ~two_d | stride_fits(size, y_low);
        size_ok = (size != ISZ_RSVD) && !(narrow_only && (size == ISZ_32));
        legal   = x_ok & y_ok & size_ok;
    end
endmodule

// File: rtl/pdma_addr_gen.sv
module pdma_addr_gen #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int MW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic          two_d,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] x_count,
    input  logic [MW-1:0] x_mod,
    input  logic [CW-1:0] y_count,
    input  logic [MW-1:0] y_mod,
    output logic [AW-1:0] ptr,
    output logic          last_item
);
    localparam int LW = CW + 1;
    localparam logic [LW-1:0] ONE = LW'(1);

    logic [LW-1:0] x_left;
    logic [LW-1:0] y_left;
    logic [LW-1:0] x_reload;
    logic [AW-1:0] x_step;
    logic [AW-1:0] y_step;
    logic [AW-1:0] ptr_q;

    // A zero count stands for the full 2^CW range.
    function automatic logic [LW-1:0] expand(input logic [CW-1:0] c);
        return (c == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, c};
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q    <= '0;
            x_left   <= ONE;
            y_left   <= ONE;
            x_reload <= ONE;
            x_step   <= '0;
            y_step   <= '0;
        end else if (load) begin
            ptr_q    <= start_addr;
            x_left   <= expand(x_count);
            x_reload <= expand(x_count);
            y_left   <= two_d ? expand(y_count) : ONE;
            x_step   <= {{(AW-MW){x_mod[MW-1]}}, x_mod};
            y_step   <= {{(AW-MW){y_mod[MW-1]}}, y_mod};
        end else if (step) begin
            if (x_left == ONE) begin
                if (y_left != ONE) begin
                    ptr_q  <= ptr_q + y_step;
                    x_left <= x_reload;
                    y_left <= y_left - ONE;
                end
            end else begin
                ptr_q  <= ptr_q + x_step;
                x_left <= x_left - ONE;
            end
        end
    end

    assign ptr       = ptr_q;
    assign last_item = (x_left == ONE) && (y_left == ONE);
endmodule

// File: rtl/pdma_beat_ctrl.sv
module pdma_beat_ctrl
    import pdma_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic            accept,
    input  item_size_e      size,
    input  logic            to_mem,
    input  logic [2*DW-1:0] wdata_in,
    input  logic            mem_ready,
    input  logic [DW-1:0]   mem_rdata,
    output logic            pending,
    output logic            high_beat,
    output logic            item_done,
    output logic [DW-1:0]   mem_wdata,
    output logic [2*DW-1:0] rdata_out,
    output logic            rvalid
);
    localparam int IW = 2 * DW;

    logic          pend_q;
    logic          high_q;
    logic [IW-1:0] wbuf_q;
    logic [DW-1:0] lo_q;
    logic [IW-1:0] rd_q;
    logic          rv_q;
    logic          handshake;
    logic          last_beat;
    logic [IW-1:0] assembled;

    always_comb begin
        last_beat = (size != ISZ_32) | high_q;
        handshake = pend_q & mem_ready & ~flush;
        item_done = handshake & last_beat;
        case (size)
            ISZ_32:  assembled = {mem_rdata, lo_q};
            ISZ_8:   assembled = {{(IW-8){1'b0}}, mem_rdata[7:0]};
            default: assembled = {{(IW-DW){1'b0}}, mem_rdata};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            pend_q <= 1'b0;
            high_q <= 1'b0;
            rv_q   <= 1'b0;
            if (rst) begin
                wbuf_q <= '0;
                lo_q   <= '0;
                rd_q   <= '0;
            end
        end else begin
            rv_q <= 1'b0;
            if (item_done) begin
                pend_q <= 1'b0;
                high_q <= 1'b0;
                rv_q   <= ~to_mem;
                rd_q   <= assembled;
            end else if (handshake) begin
                high_q <= 1'b1;
                lo_q   <= mem_rdata;
            end else if (accept) begin
                pend_q <= 1'b1;
                wbuf_q <= wdata_in;
            end
        end
    end

    assign pending   = pend_q;
    assign high_beat = high_q;
    assign mem_wdata = high_q ? wbuf_q[IW-1:DW] : wbuf_q[DW-1:0];
    assign rdata_out = rd_q;
    assign rvalid    = rv_q;
endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
    import pdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int MW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_enable,
    input  logic            cfg_to_mem,
    input  logic [1:0]      cfg_size,
    input  logic            cfg_two_d,
    input  logic [AW-1:0]   cfg_start_addr,
    input  logic [CW-1:0]   cfg_x_count,
    input  logic [MW-1:0]   cfg_x_mod,
    input  logic [CW-1:0]   cfg_y_count,
    input  logic [MW-1:0]   cfg_y_mod,
    input  logic            narrow_only,
    input  logic            periph_irq,
    input  logic [2*DW-1:0] periph_wdata,
    output logic            irq_out,
    output logic [2*DW-1:0] periph_rdata,
    output logic            periph_rvalid,
    output logic            mem_valid,
    input  logic            mem_ready,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_write,
    output logic            mem_byte,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic            busy,
    output logic            done,
    output logic            cfg_err
);
    localparam logic [AW-1:0] BEAT_BYTES = AW'(DW / 8);

    item_size_e  req_size;
    xfer_mode_t  mode_q;
    chan_state_e st_q;
    logic        en_q;
    logic        start;
    logic        legal;
    logic        accept;
    logic        pend;
    logic        high;
    logic        item_done;
    logic        last_item;
    logic        done_q;
    logic [AW-1:0] ptr;

    assign req_size = item_size_e'(cfg_size);
    assign start    = cfg_enable & ~en_q;
    assign accept   = (st_q == CH_RUN) & periph_irq & ~pend;

    pdma_cfg_check u_check (
        .size        (req_size),
        .two_d       (cfg_two_d),
        .x_low       (cfg_x_mod[1:0]),
        .y_low       (cfg_y_mod[1:0]),
        .narrow_only (narrow_only),
        .legal       (legal)
    );

    pdma_addr_gen #(.AW(AW), .CW(CW), .MW(MW)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .load       (start & legal),
        .step       (item_done),
        .two_d      (cfg_two_d),
        .start_addr (cfg_start_addr),
        .x_count    (cfg_x_count),
        .x_mod      (cfg_x_mod),
        .y_count    (cfg_y_count),
        .y_mod      (cfg_y_mod),
        .ptr        (ptr),
        .last_item  (last_item)
    );

    pdma_beat_ctrl #(.DW(DW)) u_beat (
        .clk       (clk),
        .rst       (rst),
        .flush     (~cfg_enable),
        .accept    (accept),
        .size      (mode_q.size),
        .to_mem    (mode_q.to_mem),
        .wdata_in  (periph_wdata),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .pending   (pend),
        .high_beat (high),
        .item_done (item_done),
        .mem_wdata (mem_wdata),
        .rdata_out (periph_rdata),
        .rvalid    (periph_rvalid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            st_q   <= CH_IDLE;
            mode_q <= '0;
            done_q <= 1'b0;
        end else begin
            en_q   <= cfg_enable;
            done_q <= 1'b0;
            if (!cfg_enable) begin
                st_q <= CH_IDLE;
            end else if (start) begin
                st_q   <= legal ? CH_RUN : CH_ERR;
                mode_q <= '{to_mem: cfg_to_mem, size: req_size};
            end else if (item_done && last_item) begin
                st_q   <= CH_FIN;
                done_q <= 1'b1;
            end
        end
    end

    assign irq_out   = ~cfg_enable & periph_irq;
    assign mem_valid = pend;
    assign mem_addr  = ptr + (high ? BEAT_BYTES : '0);
    assign mem_write = mode_q.to_mem;
    assign mem_byte  = (mode_q.size == ISZ_8);
    assign busy      = (st_q == CH_RUN);
    assign done      = done_q;
    assign cfg_err   = (st_q == CH_ERR);
endmodule

// File: rtl/pdma_channel_chk.sv
module pdma_channel_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_enable,
    input logic          periph_irq,
    input logic          irq_out,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic          mem_write,
    input logic          busy,
    input logic          done,
    input logic          cfg_err
);
    AST_IRQ_FORWARD: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |-> (irq_out == periph_irq)); // R1

    AST_IRQ_ABSORB: assert property (@(posedge clk) disable iff (rst)
        cfg_enable |-> !irq_out); // R1

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!mem_valid && !busy)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R9

    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (rst)
        (cfg_enable && mem_valid && !mem_ready) |=>
            (!cfg_enable || (mem_valid && $stable(mem_addr) && $stable(mem_write)))); // R6
endmodule

bind pdma_channel pdma_channel_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_enable (cfg_enable),
    .periph_irq (periph_irq),
    .irq_out    (irq_out),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_write  (mem_write),
    .busy       (busy),
    .done       (done),
    .cfg_err    (cfg_err)
);

// File: tb/pdma_channel_bench.sv
module pdma_channel_bench;
    localparam int AW = 32;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int MW = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst;
    logic          cfg_enable, cfg_to_mem, cfg_two_d, narrow_only;
    logic [1:0]    cfg_size;
    logic [AW-1:0] cfg_start_addr;
    logic [CW-1:0] cfg_x_count, cfg_y_count;
    logic [MW-1:0] cfg_x_mod, cfg_y_mod;
    logic          periph_irq = 1'b0;
    logic [31:0]   periph_wdata = '0;
    logic          irq_out, periph_rvalid, mem_valid, mem_write, mem_byte;
    logic          mem_ready = 1'b0;
    logic [31:0]   periph_rdata;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          busy, done, cfg_err;

    pdma_channel #(.AW(AW), .DW(DW), .CW(CW), .MW(MW)) u_pdma_channel (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_to_mem(cfg_to_mem),
        .cfg_size(cfg_size), .cfg_two_d(cfg_two_d), .cfg_start_addr(cfg_start_addr),
        .cfg_x_count(cfg_x_count), .cfg_x_mod(cfg_x_mod), .cfg_y_count(cfg_y_count),
        .cfg_y_mod(cfg_y_mod), .narrow_only(narrow_only), .periph_irq(periph_irq),
        .periph_wdata(periph_wdata), .irq_out(irq_out), .periph_rdata(periph_rdata),
        .periph_rvalid(periph_rvalid), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_write(mem_write), .mem_byte(mem_byte),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .cfg_err(cfg_err)
    );

    // Memory returns a pattern derived from the beat address.
    assign mem_rdata = mem_addr[15:0] ^ 16'h3C5A;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int beats    = 0;
    int dones    = 0;
    bit stream_on = 0;
    bit ready_alt = 0;
    bit finished  = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        periph_irq   <= stream_on && ((cyc % 3) != 2);
        mem_ready    <= ready_alt ? ((cyc % 2) == 0) : 1'b1;
        periph_wdata <= 32'(cyc) * 32'h9E3779B1;
    end

    // Behavioural reference model, advanced on each rising edge.
    int          m_st;      // 0 idle, 1 run, 2 finished, 3 error
    bit          m_enq, m_pend, m_beat, m_dir, m_done, m_rv;
    int          m_sz, m_xl, m_yl, m_xr, m_xm, m_ym;
    logic [31:0] m_ptr, m_w, m_rd;
    logic [15:0] m_lo;

    always @(posedge clk) begin
        if (rst || !cfg_enable) begin
            m_st = 0; m_pend = 0; m_beat = 0; m_done = 0; m_rv = 0; m_enq = 0;
            if (rst) begin m_dir = 0; m_sz = 0; end
        end else begin
            m_done = 0;
            m_rv   = 0;
            if (!m_enq) begin
                int unit;
                bit ok;
                unit = (cfg_size == 2'd0) ? 1 : (cfg_size == 2'd1) ? 2 : 4;
                ok = (cfg_size != 2'd3) && !(narrow_only && cfg_size == 2'd2)
                     && ((cfg_x_mod % unit) == 0)
                     && (!cfg_two_d || ((cfg_y_mod % unit) == 0));
                m_dir = cfg_to_mem;
                m_sz  = int'(cfg_size);
                if (ok) begin
                    m_st  = 1;
                    m_ptr = cfg_start_addr;
                    m_xr  = (cfg_x_count == 0) ? 256 : int'(cfg_x_count);
                    m_xl  = m_xr;
                    m_yl  = cfg_two_d ? ((cfg_y_count == 0) ? 256 : int'(cfg_y_count)) : 1;
                    m_xm  = int'($signed(cfg_x_mod));
                    m_ym  = int'($signed(cfg_y_mod));
                end else begin
                    m_st = 3;
                end
            end else if (m_pend && mem_ready) begin
                logic [31:0] a;
                logic [15:0] d;
                a = m_ptr + (m_beat ? 32'd2 : 32'd0);
                d = a[15:0] ^ 16'h3C5A;
                if (m_sz == 2 && !m_beat) begin
                    m_lo   = d;
                    m_beat = 1;
                end else begin
                    m_pend = 0;
                    m_beat = 0;
                    if (!m_dir) begin
                        m_rv = 1;
                        m_rd = (m_sz == 2) ? {d, m_lo} : (m_sz == 0) ? {24'd0, d[7:0]} : {16'd0, d};
                    end
                    if (m_xl == 1 && m_yl == 1) begin
                        m_st = 2; m_done = 1;
                    end else if (m_xl == 1) begin
                        m_ptr = m_ptr + m_ym; m_xl = m_xr; m_yl = m_yl - 1;
                    end else begin
                        m_ptr = m_ptr + m_xm; m_xl = m_xl - 1;
                    end
                end
            end else if (m_st == 1 && periph_irq && !m_pend) begin
                m_pend = 1;
                m_w    = periph_wdata;
            end
            m_enq = 1;
        end
    end

    // Per-cycle comparison, away from the rising edge.
    always @(negedge clk) begin
        #3;
        if (!rst && !finished) begin
            check(irq_out == (!cfg_enable && periph_irq), "R1 irq_out", 32'(irq_out), 32'(!cfg_enable && periph_irq));
            check(mem_valid == m_pend, "R6 mem_valid", 32'(mem_valid), 32'(m_pend));
            if (m_pend) begin
                logic [31:0] ea;
                ea = m_ptr + (m_beat ? 32'd2 : 32'd0);
                check(mem_addr == ea, "R3 mem_addr", mem_addr, ea);
                check(mem_write == m_dir, "R2 mem_write", 32'(mem_write), 32'(m_dir));
                check(mem_byte == (m_sz == 0), "R6 mem_byte", 32'(mem_byte), 32'(m_sz == 0));
                if (m_dir)
                    check(mem_wdata == (m_beat ? m_w[31:16] : m_w[15:0]), "R5 mem_wdata",
                          32'(mem_wdata), 32'(m_beat ? m_w[31:16] : m_w[15:0]));
            end
            check(periph_rvalid == m_rv, "R5 periph_rvalid", 32'(periph_rvalid), 32'(m_rv));
            if (m_rv) check(periph_rdata == m_rd, "R5 periph_rdata", periph_rdata, m_rd);
            check(done == m_done, "R9 done", 32'(done), 32'(m_done));
            check(busy == (m_st == 1), "R9 busy", 32'(busy), 32'(m_st == 1));
            check(cfg_err == (m_st == 3), "R7 cfg_err", 32'(cfg_err), 32'(m_st == 3));
            if (mem_valid && mem_ready) beats++;
            if (done) dones++;
        end
    end

    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog: cycles=%0d expected<100000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic run_xfer(input string tag, input bit to_mem, input logic [1:0] sz, input bit two_d,
                            input logic [31:0] start, input logic [7:0] xc, input logic [15:0] xm,
                            input logic [7:0] yc, input logic [15:0] ym, input bit narrow,
                            input bit alt, input int exp_beats, input bit exp_err);
        @(negedge clk);
        cfg_to_mem = to_mem; cfg_size = sz; cfg_two_d = two_d; cfg_start_addr = start;
        cfg_x_count = xc; cfg_x_mod = xm; cfg_y_count = yc; cfg_y_mod = ym;
        narrow_only = narrow; ready_alt = alt; beats = 0; dones = 0;
        @(negedge clk);
        cfg_enable = 1; stream_on = 1;
        for (int i = 0; i < 3000 && dones == 0 && !(exp_err && i > 30); i++) @(negedge clk);
        repeat (10) @(negedge clk);        // requests after completion are absorbed
        check(beats == exp_beats, {tag, " beat count"}, 32'(beats), 32'(exp_beats));
        check(dones == (exp_err ? 0 : 1), {tag, " done pulses"}, 32'(dones), 32'(exp_err ? 0 : 1));
        cfg_enable = 0;
        repeat (6) @(negedge clk);         // forwarded while disabled
        stream_on = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        rst = 1; cfg_enable = 0; cfg_to_mem = 0; cfg_size = 0; cfg_two_d = 0; narrow_only = 0;
        cfg_start_addr = '0; cfg_x_count = '0; cfg_x_mod = '0; cfg_y_count = '0; cfg_y_mod = '0;
        repeat (3) @(negedge clk);
        #3;
        check(!busy && !done && !cfg_err, "R9 reset idle", {29'd0, busy, done, cfg_err}, 32'd0);
        check(!mem_valid && !periph_rvalid, "R6 reset bus quiet", {30'd0, mem_valid, periph_rvalid}, 32'd0);
        @(negedge clk);
        rst = 0;
        stream_on = 1;                     // R1 passthrough while disabled
        repeat (8) @(negedge clk);
        stream_on = 0;
        run_xfer("R3 1D 16-bit write",  1, 2'd1, 0, 32'h0000_1000, 8'd5, 16'd2,      8'd0, 16'd0,      0, 0, 5, 0);
        run_xfer("R5 1D 32-bit read",   0, 2'd2, 0, 32'h0000_2000, 8'd4, 16'hFFFC,   8'd0, 16'd0,      0, 1, 8, 0);
        run_xfer("R4 2D 8-bit read",    0, 2'd0, 1, 32'h0000_3001, 8'd3, 16'd1,      8'd3, 16'd5,      0, 0, 9, 0);
        run_xfer("R4 2D 32-bit write",  1, 2'd2, 1, 32'h0000_4000, 8'd2, 16'd4,      8'd2, 16'hFFF4,   0, 1, 8, 0);
        run_xfer("R7 odd x stride",     0, 2'd1, 0, 32'h0000_5000, 8'd4, 16'd3,      8'd0, 16'd0,      0, 0, 0, 1);
        run_xfer("R7 bad y stride 2D",  1, 2'd2, 1, 32'h0000_6000, 8'd2, 16'd4,      8'd2, 16'd2,      0, 0, 0, 1);
        run_xfer("R7 y ignored in 1D",  0, 2'd1, 0, 32'h0000_7000, 8'd3, 16'd2,      8'd0, 16'd1,      0, 1, 3, 0);
        run_xfer("R8 narrow 32-bit",    0, 2'd2, 0, 32'h0000_8000, 8'd2, 16'd4,      8'd0, 16'd0,      1, 0, 0, 1);
        run_xfer("R8 size code 3",      0, 2'd3, 0, 32'h0000_9000, 8'd2, 16'd4,      8'd0, 16'd0,      0, 0, 0, 1);
        run_xfer("R8 narrow 16 legal",  1, 2'd1, 0, 32'h0000_A000, 8'd2, 16'd2,      8'd0, 16'd0,      1, 0, 2, 0);
        run_xfer("R10 zero count",      0, 2'd0, 0, 32'h0000_B000, 8'd0, 16'd1,      8'd0, 16'd0,      0, 0, 256, 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule